// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A translation starts when the requester raises a one-cycle request with the virtual address and the upper bits of the first-level table address. The walker reads one word from the first-level table. The type of that word decides the next step: the walk stops with a fault, it stops with a 1 MB section mapping, or it reads a second-level descriptor from a coarse or a fine table. The second-level descriptor then maps a 64 KB, 4 KB or 1 KB page, or it faults.

Memory is reached over a single-outstanding request/acknowledge port. The address is held steady until the acknowledge arrives, and the read data is taken in the acknowledge cycle. The result appears together with a one-cycle completion pulse. It gives the physical address, the domain, a 2-bit access-permission field, the cacheable and bufferable bits, and a fault code that says which level failed. The walker does not check permissions or domains and keeps no cache of translations.

Top module: `walk_unit`

## Requirements
- R1: After reset, `done`, `memReq` and `busy` are low, and `fault` reads 0.
- R2: The first read goes to address {tblBase, va[31:20], 2'b00}. Each read keeps `memReq` high and `memAddr` unchanged until `memAck`. A walk makes one read when the first-level descriptor is a fault or a section, and two reads otherwise.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk with fault code 1. The physical address, domain, permission, cacheable and bufferable outputs are all zero, and no second read is made.
- R4: A first-level descriptor with bits [1:0] = 10 (section) gives physical address {desc[31:20], va[19:0]}, bufferable = desc[2], cacheable = desc[3], domain = desc[8:5] and permission = desc[11:10], with fault code 0.
- R5: Type 01 (coarse) reads the second level at {desc[31:10], va[19:12], 2'b00}. Type 11 (fine) reads it at {desc[31:12], va[19:10], 2'b00}.
- R6: A second-level descriptor of type 01 (64 KB page) gives {desc[31:16], va[15:0]}. Its permission is the 2-bit field at bits [2n+5:2n+4], where n = va[15:14].
- R7: A second-level descriptor of type 10 (4 KB page) gives {desc[31:12], va[11:0]}. Its permission is the field at bits [2n+5:2n+4], where n = va[11:10].
- R8: A second-level descriptor of type 11 (1 KB page) gives {desc[31:10], va[9:0]}. Its permission is bits [5:4].
- R9: A second-level descriptor of type 00 ends the walk with fault code 2 and all other result outputs zero.
- R10: For any page result, bufferable = desc[2] and cacheable = desc[3] of the second-level descriptor, and the domain is bits [8:5] of the first-level descriptor.
- R11: `done` is high for exactly one cycle per walk. `busy` is high from the cycle after the request is accepted through the `done` cycle. A request that arrives while `busy` is high, including in the `done` cycle, is ignored and starts no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xlatReq | input | 1 | Start a translation (sampled while idle) |
| xlatVa | input | 32 | Virtual address to translate |
| tblBase | input | 18 | Bits 31:14 of the first-level table address |
| memReq | output | 1 | Read request, held until acknowledged |
| memAddr | output | 32 | Word address of the descriptor read |
| memAck | input | 1 | Read acknowledge; read data valid in this cycle |
| memRdata | input | 32 | Descriptor word returned by memory |
| busy | output | 1 | A walk is in progress or completing |
| done | output | 1 | One-cycle pulse: result outputs valid |
| physAddr | output | 32 | Translated physical address (zero on fault) |
| domain | output | 4 | Domain number from the first-level descriptor |
| perm | output | 2 | Selected access-permission field |
| cacheable | output | 1 | Cacheable attribute |
| bufferable | output | 1 | Bufferable attribute |
| fault | output | 2 | 0 none, 1 first-level fault, 2 second-level fault |

## Verification
The completion pulse of one walk and the arrival of the next request can fall in the same cycle. The bench provokes this by raising `xlatReq` exactly in the cycle where `done` is seen high. It then requires that no read starts and that `busy` drops, so the request is dropped rather than queued. In a second case a new request with a different address is held high while a two-read walk waits on memory. The bench judges it by the read count, the read addresses and the result, which must all belong to the first address only.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_W   = 18;
  localparam int DOM_W    = 4;
  localparam int AP_W     = 2;
  localparam int NUM_AP   = 4;
  localparam int AP_LSB   = 4;
  localparam int FLT_W    = 2;
  localparam int L1_SHIFT = 20;
  localparam int VAQ_W    = L1_SHIFT;

  localparam logic [1:0] K1_FAULT   = 2'b00;
  localparam logic [1:0] K1_COARSE  = 2'b01;
  localparam logic [1:0] K1_SECTION = 2'b10;
  localparam logic [1:0] K1_FINE    = 2'b11;

  localparam logic [1:0] K2_FAULT = 2'b00;
  localparam logic [1:0] K2_LARGE = 2'b01;
  localparam logic [1:0] K2_SMALL = 2'b10;
  localparam logic [1:0] K2_TINY  = 2'b11;

  localparam logic [FLT_W-1:0] FLT_NONE = 2'd0;
  localparam logic [FLT_W-1:0] FLT_LVL1 = 2'd1;
  localparam logic [FLT_W-1:0] FLT_LVL2 = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_FIN  = 2'd3
  } walkState_t;

  typedef struct packed {
    logic startWalk;
    logic takeL1;
    logic takeL2;
  } walkStrobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xlatReq,
  input  logic        memAck,
  input  logic [1:0]  descKind,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        busy,
  output logic        done
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (xlatReq) stateNext = ST_RD1;
      ST_RD1: begin
        if (memAck) begin
          if (descKind == K1_FAULT || descKind == K1_SECTION) stateNext = ST_FIN;
          else stateNext = ST_RD2;
        end
      end
      ST_RD2: if (memAck) stateNext = ST_FIN;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.startWalk = (state == ST_IDLE) && xlatReq;
    strobe.takeL1    = (state == ST_RD1) && memAck;
    strobe.takeL2    = (state == ST_RD2) && memAck;
  end

  assign memReq = (state == ST_RD1) || (state == ST_RD2);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);
endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] xlatVa,
  input  logic [BASE_W-1:0] tblBase,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic [DOM_W-1:0]  domain,
  output logic [AP_W-1:0]   perm,
  output logic              cacheable,
  output logic              bufferable,
  output logic [FLT_W-1:0]  fault
);
  logic [VAQ_W-1:0]  vaQ;
  logic [DOM_W-1:0]  domQ;
  logic [1:0]        kind;
  logic [NUM_AP-1:0][AP_W-1:0] apField;
  logic [ADDR_W-1:0] pagePa;
  logic [AP_W-1:0]   pageAp;

  assign kind = memRdata[1:0];

  for (genvar g = 0; g < NUM_AP; g++) begin : gAp
    assign apField[g] = memRdata[AP_LSB + AP_W*g +: AP_W];
  end

  always_comb begin
    case (kind)
      K2_LARGE: begin
        pagePa = {memRdata[31:16], vaQ[15:0]};
        pageAp = apField[vaQ[15:14]];
      end
      K2_SMALL: begin
        pagePa = {memRdata[31:12], vaQ[11:0]};
        pageAp = apField[vaQ[11:10]];
      end
      default: begin
        pagePa = {memRdata[31:10], vaQ[9:0]};
        pageAp = apField[0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ        <= '0;
      domQ       <= '0;
      memAddr    <= '0;
      physAddr   <= '0;
      domain     <= '0;
      perm       <= '0;
      cacheable  <= 1'b0;
      bufferable <= 1'b0;
      fault      <= FLT_NONE;
    end else begin
      if (strobe.startWalk) begin
        vaQ     <= xlatVa[VAQ_W-1:0];
        memAddr <= {tblBase, xlatVa[31:L1_SHIFT], 2'b00};
      end
      if (strobe.takeL1) begin
        domQ <= memRdata[8:5];
        case (kind)
          K1_FAULT: begin
            physAddr   <= '0;
            domain     <= '0;
            perm       <= '0;
            cacheable  <= 1'b0;
            bufferable <= 1'b0;
            fault      <= FLT_LVL1;
          end
          K1_SECTION: begin
            physAddr   <= {memRdata[31:20], vaQ[19:0]};
            domain     <= memRdata[8:5];
            perm       <= memRdata[11:10];
            cacheable  <= memRdata[3];
            bufferable <= memRdata[2];
            fault      <= FLT_NONE;
          end
          K1_COARSE: memAddr <= {memRdata[31:10], vaQ[19:12], 2'b00};
          default:   memAddr <= {memRdata[31:12], vaQ[19:10], 2'b00};
        endcase
      end
      if (strobe.takeL2) begin
        if (kind == K2_FAULT) begin
          physAddr   <= '0;
          domain     <= '0;
          perm       <= '0;
          cacheable  <= 1'b0;
          bufferable <= 1'b0;
          fault      <= FLT_LVL2;
        end else begin
          physAddr   <= pagePa;
          domain     <= domQ;
          perm       <= pageAp;
          cacheable  <= memRdata[3];
          bufferable <= memRdata[2];
          fault      <= FLT_NONE;
        end
      end
    end
  end
endmodule

// File: rtl/walk_unit.sv
module walk_unit
  import walk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              xlatReq,
  input  logic [ADDR_W-1:0] xlatVa,
  input  logic [BASE_W-1:0] tblBase,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] physAddr,
  output logic [DOM_W-1:0]  domain,
  output logic [AP_W-1:0]   perm,
  output logic              cacheable,
  output logic              bufferable,
  output logic [FLT_W-1:0]  fault
);
  walkStrobe_t strobe;

  walk_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .xlatReq  (xlatReq),
    .memAck   (memAck),
    .descKind (memRdata[1:0]),
    .strobe   (strobe),
    .memReq   (memReq),
    .busy     (busy),
    .done     (done)
  );

  walk_dpath dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .xlatVa     (xlatVa),
    .tblBase    (tblBase),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .physAddr   (physAddr),
    .domain     (domain),
    .perm       (perm),
    .cacheable  (cacheable),
    .bufferable (bufferable),
    .fault      (fault)
  );
endmodule

// File: rtl/walk_unit_chk.sv
module walk_unit_chk
  import walk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              done,
  input logic [ADDR_W-1:0] physAddr,
  input logic [DOM_W-1:0]  domain,
  input logic [AP_W-1:0]   perm,
  input logic              cacheable,
  input logic              bufferable,
  input logic [FLT_W-1:0]  fault
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  assert_l1zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault == FLT_LVL1) |-> (physAddr == '0 && domain == '0 && perm == '0));

  assert_l2zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault == FLT_LVL2) |-> (physAddr == '0 && !cacheable && !bufferable));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !memReq);

  assert_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fault != 2'd3));
endmodule

bind walk_unit walk_unit_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memAck     (memAck),
  .done       (done),
  .physAddr   (physAddr),
  .domain     (domain),
  .perm       (perm),
  .cacheable  (cacheable),
  .bufferable (bufferable),
  .fault      (fault)
);

// File: tb/walk_unit_tb_top.sv
module walk_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xlatReq = 1'b0;
  logic [31:0] xlatVa = '0;
  logic [17:0] tblBase = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic        busy, done, cacheable, bufferable;
  logic [31:0] physAddr;
  logic [3:0]  domain;
  logic [1:0]  perm, fault;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  walk_unit dut_i (
    .clk(clk), .rstN(rstN), .xlatReq(xlatReq), .xlatVa(xlatVa), .tblBase(tblBase),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memRdata(memRdata),
    .busy(busy), .done(done), .physAddr(physAddr), .domain(domain), .perm(perm),
    .cacheable(cacheable), .bufferable(bufferable), .fault(fault)
  );

  localparam int NV = 8;
  localparam logic [31:0] V_BASE [NV] = '{32'h0001_0000, 32'h0000_4000, 32'h0002_0000,
    32'h0002_0000, 32'h0002_0000, 32'h0002_0000, 32'h0002_0000, 32'hFFFF_C000};
  localparam logic [31:0] V_VA [NV] = '{32'h1234_5678, 32'hFFF0_0000, 32'h0045_6C00,
    32'h0056_8123, 32'h00AB_CDEF, 32'h0010_0000, 32'h0000_1400, 32'hFFF0_0001};
  localparam logic [31:0] V_D1 [NV] = '{32'hABC0_08AE, 32'hFFFF_FFFC, 32'h0030_0521,
    32'h0040_0061, 32'h0050_11E3, 32'h0060_0001, 32'h0070_0003, 32'h0010_0002};
  localparam logic [31:0] V_D2 [NV] = '{32'h0, 32'h0, 32'h7777_7E4A,
    32'h1234_01B5, 32'h9876_542F, 32'hFFFF_FFFC, 32'h0BAD_C082, 32'h0};
  localparam logic [31:0] V_L2A [NV] = '{32'h0, 32'h0, 32'h0030_0558,
    32'h0040_01A0, 32'h0050_1BCC, 32'h0060_0000, 32'h0070_0014, 32'h0};
  localparam int V_NRD [NV] = '{1, 1, 2, 2, 2, 2, 2, 1};
  localparam logic [31:0] V_PA [NV] = '{32'hABC4_5678, 32'h0, 32'h7777_7C00,
    32'h1234_8123, 32'h9876_55EF, 32'h0, 32'h0BAD_C400, 32'h0010_0001};
  localparam logic [3:0] V_DOM [NV] = '{4'd5, 4'd0, 4'd9, 4'd3, 4'd15, 4'd0, 4'd0, 4'd0};
  localparam logic [1:0] V_AP  [NV] = '{2'd2, 2'd0, 2'd3, 2'd1, 2'd2, 2'd0, 2'd2, 2'd0};
  localparam logic       V_C   [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic       V_B   [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [1:0] V_FLT [NV] = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0};

  function automatic string tagOf(int i);
    case (i)
      0, 7:    return "R4";
      1:       return "R3";
      2, 6:    return "R7/R10";
      3:       return "R6/R10";
      4:       return "R8/R10";
      default: return "R9";
    endcase
  endfunction

  logic [31:0] curL1A = '0, curD1 = '0, curD2 = '0;
  int          memLat = 0;
  int          waitCnt = 0;
  int          txCount = 0;
  logic [31:0] addrLog [2];

  // memory model: acknowledges after memLat idle cycles, one word per request
  initial begin
    addrLog[0] = '0;
    addrLog[1] = '0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
      end else if (memReq) begin
        if (waitCnt < memLat) waitCnt++;
        else begin
          memAck   = 1'b1;
          memRdata = (memAddr == curL1A) ? curD1 : curD2;
          if (txCount < 2) addrLog[txCount] = memAddr;
          txCount++;
          waitCnt = 0;
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(int i, int lat);
    curL1A  = {V_BASE[i][31:14], V_VA[i][31:20], 2'b00};
    curD1   = V_D1[i];
    curD2   = V_D2[i];
    memLat  = lat;
    txCount = 0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkResult(int i);
    string t = tagOf(i);
    chk({t, " pa"}, physAddr, V_PA[i]);
    chk({t, " domain"}, {28'd0, domain}, {28'd0, V_DOM[i]});
    chk({t, " perm"}, {30'd0, perm}, {30'd0, V_AP[i]});
    chk({t, " cacheable"}, {31'd0, cacheable}, {31'd0, V_C[i]});
    chk({t, " bufferable"}, {31'd0, bufferable}, {31'd0, V_B[i]});
    chk({t, " fault code"}, {30'd0, fault}, {30'd0, V_FLT[i]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 memReq", {31'd0, memReq}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 fault", {30'd0, fault}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      setup(i, i % 3);
      xlatReq = 1'b1;
      xlatVa  = V_VA[i];
      tblBase = V_BASE[i][31:14];
      @(negedge clk);
      xlatReq = 1'b0;
      chk("R11 busy during walk", {31'd0, busy}, 32'd1);
      waitDone();
      checkResult(i);
      chk("R2 read count", txCount, V_NRD[i]);
      chk("R2 first-level address", addrLog[0], curL1A);
      if (V_NRD[i] == 2) chk("R5 second-level address", addrLog[1], V_L2A[i]);
      @(negedge clk);
      chk("R11 done one cycle", {31'd0, done}, 32'd0);
      @(negedge clk);
    end

    // R11: a second request held high during a walk is ignored
    setup(3, 3);
    xlatReq = 1'b1;
    xlatVa  = V_VA[3];
    tblBase = V_BASE[3][31:14];
    @(negedge clk);
    xlatVa  = V_VA[0];
    tblBase = V_BASE[0][31:14];
    @(negedge clk);
    @(negedge clk);
    xlatReq = 1'b0;
    waitDone();
    checkResult(3);
    chk("R11 busy request read count", txCount, 2);
    chk("R11 busy request address", addrLog[0], curL1A);

    // R11: request arriving in the done cycle is dropped
    xlatReq = 1'b1;
    xlatVa  = V_VA[0];
    @(negedge clk);
    xlatReq = 1'b0;
    txCount = 0;
    for (int k = 0; k < 4; k++) begin
      chk("R11 no read after done-cycle request", {31'd0, memReq}, 32'd0);
      chk("R11 idle after done-cycle request", {31'd0, busy}, 32'd0);
      @(negedge clk);
    end
    chk("R11 done-cycle request reads", txCount, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule